// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Byte-Wide Non-Volatile Memory

This block lets a clocked host reach an external byte-wide non-volatile memory that has an SRAM-style asynchronous interface. The host side is a request channel with a valid/ready handshake. Each request carries a direction, a 17-bit address and a write byte. A one-cycle response pulse returns the read byte and an error flag. The memory side drives the address, three active-low strobes (select, write, output) and a data bus that is split into an output value, an output-enable and an input value.

After reset the controller holds the host off for a startup interval, which the memory needs once its core supply has settled. It then runs one access at a time. Each access keeps the strobes active for a whole number of clock cycles, and that number covers the minimum access time. Access time and startup time are given in nanoseconds, and the clock period is given in picoseconds. A write-inhibit input stands for a supply-low flag. While it is high, a write is refused or cut short and reported as an error, and reads go ahead as normal.

Top module: `nvm_async_ctrl`

## Requirements
- R1: From reset until BOOT_CYC rising clock edges have passed with reset low, reqReady is low, memCeN, memWeN and memOeN are high and memDqOe is low. A request held valid during this interval is accepted at the first edge after it.
- R2: Outside the strobe period of an access, memCeN is high and memDqOe is low.
- R3: A read accepted at an edge drives memCeN low, memOeN low, memWeN high and memDqOe low for exactly ACC_CYC cycles. These cycles begin with the cycle after acceptance.
- R4: A write accepted with wrInhibit low drives memCeN low, memWeN low, memOeN high and memDqOe high, with memDqOut equal to the request byte. This lasts exactly ACC_CYC cycles, beginning with the cycle after acceptance.
- R5: A read samples memDqIn at the last clock edge of its strobe period. In the cycle right after the strobes end, rspValid is high for exactly one cycle, rspRdata holds the sampled byte and rspErr is low.
- R6: A write accepted while wrInhibit is high asserts no strobe. In the next cycle rspValid and rspErr are both high. A read ignores wrInhibit.
- R7: If wrInhibit is high at any clock edge during a write strobe period, memWeN and memCeN go high in the next cycle, and in that same cycle rspValid and rspErr are high.
- R8: While memCeN is low, memAddr equals the accepted request address and does not change.
- R9: memDqOe is never high in the cycle before memOeN falls, and never high while memOeN is low.
- R10: reqReady is high only when the controller is idle. It is low from the edge that accepts a request through the response cycle, so only one access is in flight at a time.
- R11: ACC_CYC equals ACCESS_NS*1000 divided by CLK_PERIOD_PS, rounded up. BOOT_CYC equals STARTUP_NS*1000 divided by CLK_PERIOD_PS, rounded up. Both are at least 1. The defaults give 5 and 200000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Request byte address |
| reqWdata | input | 8 | Byte to write |
| rspValid | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Completion was a refused or aborted write |
| rspRdata | output | 8 | Byte returned by the last read |
| wrInhibit | input | 1 | Supply-low flag; blocks writes |
| memAddr | output | 17 | Memory address |
| memCeN | output | 1 | Memory select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memOeN | output | 1 | Memory output strobe, active low |
| memDqOut | output | 8 | Data driven toward the memory |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 8 | Data coming from the memory |

## Verification
The bench sets a 4000 ps clock period, a 45 ns access time and a 300 ns startup time. This gives a 12-cycle access, which is rounded up from 11.25 cycles, and a 75-cycle startup. The end of startup and the rounding are therefore both reached within a short run. The bench memory drives meaningless data until the final strobe cycle of a read, so any capture made too early shows up as a wrong byte. Write-inhibit is raised both at acceptance and partway through a strobe period. A write followed by a read at the same address exercises the bus turnaround.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RESP
  } ctrl_state_t;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic selN;     // memory select, active low
    logic wrN;      // write strobe, active low
    logic rdN;      // output strobe, active low
    logic drive;    // drive the data bus
    logic take;     // latch the request fields
    logic capture;  // sample the read byte
    logic respond;  // completion cycle
    logic fault;    // completion is an error
  } ctrl_strobe_t;

  // Round-up conversion from nanoseconds to clock cycles, never below 1
  function automatic int unsigned cyclesFor(input longint unsigned ns,
                                            input longint unsigned periodPs);
    longint unsigned c;
    c = (ns * 64'd1000 + periodPs - 64'd1) / periodPs;
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

endpackage

// File: rtl/nvm_ctrl_fsm.sv
module nvm_ctrl_fsm
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned ACC_CYC  = 5,
  parameter int unsigned BOOT_CYC = 200000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         wrInhibit,
  output logic         reqReady,
  output ctrl_strobe_t strb
);

  localparam int unsigned SPAN = (BOOT_CYC > ACC_CYC) ? BOOT_CYC : ACC_CYC;
  localparam int unsigned CW   = $clog2(SPAN + 1);
  localparam logic [CW-1:0] BOOT_LAST = CW'(BOOT_CYC - 1);
  localparam logic [CW-1:0] ACC_LAST  = CW'(ACC_CYC - 1);

  ctrl_state_t   state;
  logic [CW-1:0] cnt;
  logic          errQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_BOOT;
      cnt   <= '0;
      errQ  <= 1'b0;
    end else begin
      case (state)
        ST_BOOT: begin
          if (cnt == BOOT_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_IDLE: begin
          cnt <= '0;
          if (reqValid) begin
            if (reqWrite && wrInhibit) begin
              state <= ST_RESP;
              errQ  <= 1'b1;
            end else begin
              state <= reqWrite ? ST_WRITE : ST_READ;
              errQ  <= 1'b0;
            end
          end
        end
        ST_READ: begin
          if (cnt == ACC_LAST) begin
            state <= ST_RESP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WRITE: begin
          if (wrInhibit) begin
            state <= ST_RESP;
            errQ  <= 1'b1;
            cnt   <= '0;
          end else if (cnt == ACC_LAST) begin
            state <= ST_RESP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_BOOT;
      endcase
    end
  end

  always_comb begin
    reqReady     = (state == ST_IDLE);
    strb.selN    = !((state == ST_READ) || (state == ST_WRITE));
    strb.wrN     = (state != ST_WRITE);
    strb.rdN     = (state != ST_READ);
    strb.drive   = (state == ST_WRITE);
    strb.take    = (state == ST_IDLE) && reqValid;
    strb.capture = (state == ST_READ) && (cnt == ACC_LAST);
    strb.respond = (state == ST_RESP);
    strb.fault   = errQ;
  end

endmodule

// File: rtl/nvm_ctrl_dp.sv
module nvm_ctrl_dp
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobe_t      strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strb.take) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdataQ <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memDqOe  = strb.drive;
  assign memCeN   = strb.selN;
  assign memWeN   = strb.wrN;
  assign memOeN   = strb.rdN;
  assign rspValid = strb.respond;
  assign rspErr   = strb.respond & strb.fault;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/nvm_async_ctrl.sv
module nvm_async_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned ACCESS_NS     = 45,
  parameter int unsigned STARTUP_NS    = 2000000,
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  input  logic              wrInhibit,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int unsigned ACC_CYC  = cyclesFor(64'(ACCESS_NS), 64'(CLK_PERIOD_PS));
  localparam int unsigned BOOT_CYC = cyclesFor(64'(STARTUP_NS), 64'(CLK_PERIOD_PS));

  ctrl_strobe_t strb;

  nvm_ctrl_fsm #(
    .ACC_CYC (ACC_CYC),
    .BOOT_CYC(BOOT_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .wrInhibit(wrInhibit),
    .reqReady (reqReady),
    .strb     (strb)
  );

  nvm_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .rspValid(rspValid),
    .rspErr  (rspErr),
    .rspRdata(rspRdata)
  );

endmodule

// File: rtl/nvm_async_ctrl_chk.sv
module nvm_async_ctrl_chk
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned STARTUP_NS    = 2000000,
  parameter int unsigned ADDR_W        = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic              wrInhibit,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDqOe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rspValid,
  input logic              rspErr
);

  localparam int unsigned BOOT_CYC = cyclesFor(64'(STARTUP_NS), 64'(CLK_PERIOD_PS));

  int unsigned bootSeen;

  always_ff @(posedge clk) begin
    if (rst) bootSeen <= 0;
    else if (bootSeen < BOOT_CYC) bootSeen <= bootSeen + 1;
  end

  assert_boot_holdoff_R1: assert property (@(posedge clk) disable iff (rst)
    (bootSeen < BOOT_CYC) |-> (!reqReady && memCeN && memWeN && memOeN));

  assert_idle_release_R2: assert property (@(posedge clk) disable iff (rst)
    memCeN |-> !memDqOe);

  assert_read_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> (!memCeN && memWeN));

  assert_write_drive_R4: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> (!memCeN && memDqOe && memOeN));

  assert_single_rsp_R5: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

  assert_refuse_write_R6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && reqWrite && wrInhibit) |=> (memCeN && rspValid && rspErr));

  assert_abort_write_R7: assert property (@(posedge clk) disable iff (rst)
    (!memWeN && wrInhibit) |=> (memWeN && memCeN && rspValid && rspErr));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!memCeN && !$past(memCeN)) |-> $stable(memAddr));

  assert_turnaround_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(memOeN) |-> !$past(memDqOe));

  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (!memCeN || rspValid) |-> !reqReady);

endmodule

bind nvm_async_ctrl nvm_async_ctrl_chk #(
  .CLK_PERIOD_PS(CLK_PERIOD_PS),
  .STARTUP_NS   (STARTUP_NS),
  .ADDR_W       (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqWrite (reqWrite),
  .wrInhibit(wrInhibit),
  .memCeN   (memCeN),
  .memWeN   (memWeN),
  .memOeN   (memOeN),
  .memDqOe  (memDqOe),
  .memAddr  (memAddr),
  .rspValid (rspValid),
  .rspErr   (rspErr)
);

// File: tb/nvm_async_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_async_ctrl_tb;

  localparam int PERIOD_PS = 4000;
  localparam int ACC_NS    = 45;
  localparam int BOOT_NS   = 300;
  // R11: expected rounded-up cycle counts, worked out by hand
  localparam int ACC_EXP   = 12;
  localparam int BOOT_EXP  = 75;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        wrInhibit = 1'b0;
  logic [7:0]  memDqIn = '0;
  logic        reqReady, rspValid, rspErr;
  logic [7:0]  rspRdata, memDqOut;
  logic [16:0] memAddr;
  logic        memCeN, memWeN, memOeN, memDqOe;

  always #2 clk = ~clk;

  nvm_async_ctrl #(
    .CLK_PERIOD_PS(PERIOD_PS),
    .ACCESS_NS    (ACC_NS),
    .STARTUP_NS   (BOOT_NS)
  ) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .wrInhibit(wrInhibit), .memAddr(memAddr), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit started = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 idle, 1 read, 2 write, 3 response
  int          mStart = BOOT_EXP;
  int          mKind = 0;
  int          mLeft = 0;
  bit          mErr = 0;
  bit          mIsRd = 0;
  logic [16:0] mAddr = '0;
  logic [7:0]  mData = '0;
  logic [7:0]  mExpRd = '0;
  logic [7:0]  expMem [int];

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      mStart = BOOT_EXP; mKind = 0; mLeft = 0; mErr = 0;
    end else begin
      case (mKind)
        0: if (mStart > 0) mStart--;
           else if (reqValid) begin
             mAddr = reqAddr; mData = reqWdata; mIsRd = !reqWrite;
             mExpRd = expMem.exists(int'(reqAddr)) ? expMem[int'(reqAddr)] : 8'h00;
             if (reqWrite && wrInhibit) begin mKind = 3; mErr = 1; end
             else begin mKind = reqWrite ? 2 : 1; mLeft = ACC_EXP; mErr = 0; end
           end
        1: begin mLeft--; if (mLeft == 0) mKind = 3; end
        2: if (wrInhibit) begin mKind = 3; mErr = 1; end
           else begin
             mLeft--;
             if (mLeft == 0) begin mKind = 3; expMem[int'(mAddr)] = mData; end
           end
        default: mKind = 0;
      endcase
    end
  end

  // Bench memory: read data only valid in the last strobe cycle
  logic [7:0] mem [int];
  int rdRun = 0, wrRun = 0, lastRdLen = 0;
  logic [16:0] wrAddr;
  logic [7:0]  wrData;
  always @(negedge clk) begin
    if (!memCeN && !memOeN && memWeN) begin
      rdRun++;
      lastRdLen = rdRun;
      memDqIn <= (rdRun >= ACC_EXP) ? (mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 8'h00)
                                    : (8'hA5 ^ 8'(rdRun));
    end else begin
      rdRun = 0;
      memDqIn <= 8'h00;
    end
    if (!memCeN && !memWeN) begin
      wrRun++; wrAddr = memAddr; wrData = memDqOut;
    end else begin
      if (wrRun >= ACC_EXP) mem[int'(wrAddr)] = wrData;
      wrRun = 0;
    end
  end

  // Per-cycle comparison against the reference
  bit prevDqOe = 0;
  always @(negedge clk) begin
    if (started && !done) begin
      chk(mStart > 0 ? "R1" : "R10", reqReady, (mStart == 0 && mKind == 0));
      chk("R2", memCeN, !(mKind == 1 || mKind == 2));
      chk("R3", memOeN, mKind != 1);
      chk("R4", memWeN, mKind != 2);
      chk("R4", memDqOe, mKind == 2);
      if (mKind == 1 || mKind == 2) chk("R8", memAddr, mAddr);
      if (mKind == 2) chk("R4", memDqOut, mData);
      chk("R5", rspValid, mKind == 3);
      if (mKind == 3) begin
        chk(mIsRd ? "R5" : "R6", rspErr, mErr);
        if (mIsRd) chk("R5", rspRdata, mExpRd);
      end
      chk("R9", prevDqOe && !memOeN, 0);
      prevDqOe = memDqOe;
    end
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    while (!rspValid) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: request pending through the hold-off
    reqValid = 1; reqWrite = 0; reqAddr = 17'h00010;
    n = 0;
    while (!reqReady) begin @(negedge clk); n++; end
    chk("R11", n, BOOT_EXP);
    @(negedge clk);
    reqValid = 0;
    while (!rspValid) @(negedge clk);
    @(negedge clk);
    chk("R11", lastRdLen, ACC_EXP);

    issue(1, 17'h1ABCD, 8'h5A);               // R4
    issue(1, 17'h00000, 8'hFF);
    issue(1, 17'h1FFFF, 8'h01);
    issue(0, 17'h1ABCD, 8'h00);               // R5
    issue(0, 17'h1FFFF, 8'h00);
    issue(1, 17'h00777, 8'hC3);               // R9: write then read same byte
    issue(0, 17'h00777, 8'h00);
    // R6: refused write, old value must survive
    wrInhibit = 1;
    issue(1, 17'h1ABCD, 8'h11);
    issue(0, 17'h1ABCD, 8'h00);               // read ignores inhibit
    wrInhibit = 0;
    issue(0, 17'h1ABCD, 8'h00);
    chk("R6", rspRdata, 8'h5A);
    // R7: inhibit rises partway through a write
    reqValid = 1; reqWrite = 1; reqAddr = 17'h00000; reqWdata = 8'h33;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    repeat (3) @(negedge clk);
    wrInhibit = 1;
    while (!rspValid) @(negedge clk);
    @(negedge clk);
    wrInhibit = 0;
    issue(0, 17'h00000, 8'h00);
    chk("R7", rspRdata, 8'hFF);
    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule